// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block turns a single multiple-register transfer request into a run of single-word transfers, one per register named in a 16-bit register mask. Each issued transfer carries a register index, a word address and a load/store direction over a valid/ready handshake. When the last word has moved, a completion record is presented over a second handshake. The record carries the base-register update value, a flag that says whether that update applies, an illegal-encoding flag, and the outcome of any program-counter load.

Two address modes are supported. The ascending mode visits registers from the lowest index upward, with addresses rising from the base. The descending mode visits them from the highest index downward, with addresses falling from the base. A stack flag turns the request into a push (a descending store) or a pop (an ascending load), using register 13 as the base with writeback forced. Illegal requests are refused without issuing any transfer. The register file, the memory port and condition evaluation belong to the surrounding pipeline.

Top module: `mrt_seq`

## Requirements
- R1: With `req_dec`=0, transfer k (k from 0) names the k-th lowest set bit of the mask and uses address base + 4*k.
- R2: With `req_dec`=1, transfer k names the k-th highest set bit of the mask and uses address base - 4*k.
- R3: The completion record gives `done_wb_value` = base + 4*(n-1) in ascending mode and base - 4*(n-1) in descending mode, where n is the number of set mask bits. `done_wb_en` is 1 only for a legal request with writeback, and `done_wb_idx` is the effective base index.
- R4: With `req_stack`=1, the base index becomes 13 and writeback is forced. A store then runs descending and a load runs ascending, whatever `req_base_idx`, `req_wb` and `req_dec` say.
- R5: A request is illegal when any of the following holds: the base index is 15; mask bit 13 is set; the mask is zero; it is a store with mask bit 15 set; it is a load with both bits 14 and 15 set; writeback is on and the base index's own mask bit is set. An illegal request issues no transfer, and its completion record (`done_illegal`=1) is valid in the cycle after acceptance.
- R6: When a load transfers register 15, bit 0 of `xfer_rdata` in that handshake is inspected. If it is 0, `done_fault`=1. If it is 1, `done_branch`=1 and `done_target` holds that word with bit 0 cleared.
- R7: While `xfer_valid` is high and `xfer_ready` is low, `xfer_idx` and `xfer_addr` hold their values.
- R8: `req_ready` is high only when idle. It falls on acceptance and stays low until the completion handshake. One transfer completes in each cycle in which `xfer_ready` is high.
- R9: Synchronous active-high reset leaves the block idle, with `xfer_valid`=0, `done_valid`=0 and `req_ready`=1.
- R10: `xfer_load` equals the request's load flag for every transfer, and exactly n transfers are issued for a legal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mask | input | 16 | Register selection mask |
| req_base_idx | input | 4 | Base register index |
| req_base | input | 32 | Base address value |
| req_dec | input | 1 | 1 = descending from base, 0 = ascending |
| req_load | input | 1 | 1 = load, 0 = store |
| req_wb | input | 1 | Update the base register on completion |
| req_stack | input | 1 | Push/pop alias on register 13 |
| xfer_valid | output | 1 | Transfer offered |
| xfer_ready | input | 1 | Transfer taken |
| xfer_idx | output | 4 | Register index of this transfer |
| xfer_addr | output | 32 | Word address of this transfer |
| xfer_load | output | 1 | Direction of this transfer |
| xfer_rdata | input | 32 | Loaded word, sampled in the handshake cycle |
| done_valid | output | 1 | Completion record offered |
| done_ready | input | 1 | Completion record taken |
| done_illegal | output | 1 | Request was refused |
| done_wb_en | output | 1 | Base update applies |
| done_wb_idx | output | 4 | Register to update |
| done_wb_value | output | 32 | Base update value |
| done_fault | output | 1 | Loaded program counter had bit 0 clear |
| done_branch | output | 1 | Loaded program counter is a branch target |
| done_target | output | 32 | Branch target with bit 0 cleared |

## Verification
The capture of the program-counter word can fall in the same cycle as the transition to completion, because in ascending loads register 15 is always the final transfer. In descending loads it is the first, so the captured outcome must survive the rest of the run. The bench sweeps both orders with odd and even loaded words under random ready stalls. It judges the fault, branch and target fields of the record that follows. It also holds `req_valid` high for the whole run and checks that no second acceptance coincides with the outstanding completion record.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } mrt_state_e;
endpackage

// File: rtl/mrt_pick.sv
// Selects the next register to visit: lowest set bit or highest set bit.
module mrt_pick #(
   parameter int NREG = 16,
   localparam int IW = $clog2(NREG)
) (
   input  logic [NREG-1:0] mask,
   input  logic            from_top,
   output logic [IW-1:0]   idx
);
   logic [IW-1:0] lo_idx;
   logic [IW-1:0] hi_idx;

   always_comb begin
      lo_idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (mask[i]) lo_idx = IW'(i);
      end
   end

   always_comb begin
      hi_idx = '0;
      for (int i = 0; i < NREG; i++) begin
         if (mask[i]) hi_idx = IW'(i);
      end
   end

   assign idx = from_top ? hi_idx : lo_idx;
endmodule

// File: rtl/mrt_rules.sv
// Counts the mask and judges the encoding restrictions.
module mrt_rules #(
   parameter int NREG   = 16,
   parameter int SP_IDX = 13,
   parameter int LR_IDX = 14,
   parameter int PC_IDX = 15,
   localparam int IW = $clog2(NREG),
   localparam int CW = $clog2(NREG + 1)
) (
   input  logic [NREG-1:0] mask,
   input  logic [IW-1:0]   base_idx,
   input  logic            is_load,
   input  logic            wb,
   output logic            illegal,
   output logic [CW-1:0]   count
);
   logic [CW-1:0] part [NREG+1];
   assign part[0] = '0;
   for (genvar g = 0; g < NREG; g++) begin : g_cnt
      assign part[g+1] = part[g] + CW'(mask[g]);
   end
   assign count = part[NREG];

   logic bad_base, bad_sp, bad_empty, bad_st_pc, bad_ld_pclr, bad_wb_self;
   assign bad_base    = (base_idx == IW'(PC_IDX));
   assign bad_sp      = mask[SP_IDX];
   assign bad_empty   = (mask == '0);
   assign bad_st_pc   = !is_load && mask[PC_IDX];
   assign bad_ld_pclr = is_load && mask[PC_IDX] && mask[LR_IDX];
   assign bad_wb_self = wb && mask[base_idx];
   assign illegal = bad_base | bad_sp | bad_empty | bad_st_pc | bad_ld_pclr | bad_wb_self;
endmodule

// File: rtl/mrt_seq.sv
module mrt_seq #(
   parameter int NREG       = 16,
   parameter int AW         = 32,
   parameter int WORD_BYTES = 4,
   parameter int SP_IDX     = 13,
   parameter int LR_IDX     = 14,
   parameter int PC_IDX     = 15,
   localparam int IW = $clog2(NREG),
   localparam int CW = $clog2(NREG + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [NREG-1:0] req_mask,
   input  logic [IW-1:0]   req_base_idx,
   input  logic [AW-1:0]   req_base,
   input  logic            req_dec,
   input  logic            req_load,
   input  logic            req_wb,
   input  logic            req_stack,
   output logic            xfer_valid,
   input  logic            xfer_ready,
   output logic [IW-1:0]   xfer_idx,
   output logic [AW-1:0]   xfer_addr,
   output logic            xfer_load,
   input  logic [AW-1:0]   xfer_rdata,
   output logic            done_valid,
   input  logic            done_ready,
   output logic            done_illegal,
   output logic            done_wb_en,
   output logic [IW-1:0]   done_wb_idx,
   output logic [AW-1:0]   done_wb_value,
   output logic            done_fault,
   output logic            done_branch,
   output logic [AW-1:0]   done_target
);
   import mrt_pkg::*;

   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   if (NREG <= PC_IDX || NREG <= SP_IDX || NREG <= LR_IDX) begin : g_bad_nreg
      $error("mrt_seq: NREG must cover the special register indices");
   end
   if ((1 << IW) != NREG) begin : g_bad_pow2
      $error("mrt_seq: NREG must be a power of two");
   end
   if (WORD_BYTES < 1 || AW < 2) begin : g_bad_word
      $error("mrt_seq: word size parameters out of range");
   end

   mrt_state_e     st;
   logic [NREG-1:0] rem_q;
   logic [AW-1:0]   addr_q;
   logic            dec_q, ld_q, wb_q, ill_q, fault_q, branch_q;
   logic [IW-1:0]   bidx_q;
   logic [AW-1:0]   wbv_q, tgt_q;

   // Effective request after the stack alias is applied
   logic [IW-1:0] eff_idx;
   logic          eff_wb, eff_dec;
   assign eff_idx = req_stack ? IW'(SP_IDX) : req_base_idx;
   assign eff_wb  = req_stack | req_wb;
   assign eff_dec = req_stack ? ~req_load : req_dec;

   logic          rule_ill;
   logic [CW-1:0] rule_cnt;
   mrt_rules #(.NREG(NREG), .SP_IDX(SP_IDX), .LR_IDX(LR_IDX), .PC_IDX(PC_IDX)) rules_i (
      .mask(req_mask), .base_idx(eff_idx), .is_load(req_load), .wb(eff_wb),
      .illegal(rule_ill), .count(rule_cnt)
   );

   logic [IW-1:0] cur_idx;
   mrt_pick #(.NREG(NREG)) pick_i (.mask(rem_q), .from_top(dec_q), .idx(cur_idx));

   logic [AW-1:0] span;
   assign span = (AW'(rule_cnt) - AW'(1)) * STEP;

   logic accept, fire;
   logic [NREG-1:0] rem_clr;
   assign accept  = req_valid && req_ready;
   assign fire    = xfer_valid && xfer_ready;
   assign rem_clr = rem_q & ~(NREG'(1) << cur_idx);

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= ST_IDLE;
         rem_q    <= '0;
         addr_q   <= '0;
         dec_q    <= 1'b0;
         ld_q     <= 1'b0;
         wb_q     <= 1'b0;
         ill_q    <= 1'b0;
         fault_q  <= 1'b0;
         branch_q <= 1'b0;
         bidx_q   <= '0;
         wbv_q    <= '0;
         tgt_q    <= '0;
      end else begin
         case (st)
            ST_IDLE: if (accept) begin
               dec_q    <= eff_dec;
               ld_q     <= req_load;
               wb_q     <= eff_wb;
               bidx_q   <= eff_idx;
               ill_q    <= rule_ill;
               fault_q  <= 1'b0;
               branch_q <= 1'b0;
               tgt_q    <= '0;
               addr_q   <= req_base;
               wbv_q    <= eff_dec ? req_base - span : req_base + span;
               rem_q    <= rule_ill ? '0 : req_mask;
               st       <= rule_ill ? ST_DONE : ST_RUN;
            end
            ST_RUN: if (fire) begin
               rem_q  <= rem_clr;
               addr_q <= dec_q ? addr_q - STEP : addr_q + STEP;
               if (ld_q && cur_idx == IW'(PC_IDX)) begin
                  if (xfer_rdata[0]) begin
                     branch_q <= 1'b1;
                     tgt_q    <= {xfer_rdata[AW-1:1], 1'b0};
                  end else begin
                     fault_q  <= 1'b1;
                  end
               end
               if (rem_clr == '0) st <= ST_DONE;
            end
            ST_DONE: if (done_ready) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st == ST_IDLE);
   assign xfer_valid    = (st == ST_RUN);
   assign xfer_idx      = cur_idx;
   assign xfer_addr     = addr_q;
   assign xfer_load     = ld_q;
   assign done_valid    = (st == ST_DONE);
   assign done_illegal  = ill_q;
   assign done_wb_en    = wb_q & ~ill_q;
   assign done_wb_idx   = bidx_q;
   assign done_wb_value = wbv_q;
   assign done_fault    = fault_q;
   assign done_branch   = branch_q;
   assign done_target   = tgt_q;

   p_step_up_r1: assert property (@(posedge clk) disable iff (rst)
      (xfer_valid && xfer_ready && !dec_q) |=>
         (!xfer_valid || (xfer_addr == $past(xfer_addr) + STEP && xfer_idx > $past(xfer_idx))));

   p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
      (xfer_valid && xfer_ready && dec_q) |=>
         (!xfer_valid || (xfer_addr == $past(xfer_addr) - STEP && xfer_idx < $past(xfer_idx))));

   p_no_wb_on_ill_r3: assert property (@(posedge clk) disable iff (rst)
      (done_valid && done_illegal) |-> !done_wb_en);

   p_ill_fast_r5: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && rule_ill) |=> (done_valid && done_illegal && !xfer_valid));

   p_pc_excl_r6: assert property (@(posedge clk) disable iff (rst)
      done_valid |-> !(done_fault && done_branch));

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_idx) && $stable(xfer_addr)));

   p_busy_r8: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/mrt_seq_tb_top.sv
module mrt_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid, req_ready;
   logic [15:0] req_mask;
   logic [3:0]  req_base_idx;
   logic [31:0] req_base;
   logic        req_dec, req_load, req_wb, req_stack;
   logic        xfer_valid, xfer_ready, xfer_load;
   logic [3:0]  xfer_idx;
   logic [31:0] xfer_addr, xfer_rdata;
   logic        done_valid, done_ready, done_illegal, done_wb_en, done_fault, done_branch;
   logic [3:0]  done_wb_idx;
   logic [31:0] done_wb_value, done_target;

   int vectors = 0;
   int fails   = 0;
   logic [31:0] lcg = 32'h1234_5678;

   always #5 clk = ~clk;

   mrt_seq dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_mask(req_mask), .req_base_idx(req_base_idx), .req_base(req_base),
      .req_dec(req_dec), .req_load(req_load), .req_wb(req_wb), .req_stack(req_stack),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_idx(xfer_idx),
      .xfer_addr(xfer_addr), .xfer_load(xfer_load), .xfer_rdata(xfer_rdata),
      .done_valid(done_valid), .done_ready(done_ready), .done_illegal(done_illegal),
      .done_wb_en(done_wb_en), .done_wb_idx(done_wb_idx), .done_wb_value(done_wb_value),
      .done_fault(done_fault), .done_branch(done_branch), .done_target(done_target)
   );

   function automatic logic [31:0] rnd();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   task automatic run_req(input logic [15:0] m, input logic [3:0] bi, input logic [31:0] b,
                          input logic dec, input logic ld, input logic wb, input logic stk,
                          input logic [31:0] pcw);
      logic [3:0]  ei;
      logic        ew, ed, ill, fin;
      int          n, k, cyc;
      logic [3:0]  order [16];
      logic [31:0] ewv;
      ei  = stk ? 4'd13 : bi;
      ew  = stk | wb;
      ed  = stk ? ~ld : dec;
      ill = (ei == 4'd15) | m[13] | (m == 16'h0) | (!ld & m[15]) | (ld & m[15] & m[14]) | (ew & m[ei]);
      n = 0;
      if (!ed) begin
         for (int i = 0; i < 16; i++) if (m[i]) begin order[n] = 4'(i); n++; end
      end else begin
         for (int i = 15; i >= 0; i--) if (m[i]) begin order[n] = 4'(i); n++; end
      end
      ewv = ed ? b - 32'(4 * (n - 1)) : b + 32'(4 * (n - 1));
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 idle ready", 32'(req_ready), 1);
      req_mask = m; req_base_idx = bi; req_base = b; req_dec = dec;
      req_load = ld; req_wb = wb; req_stack = stk; req_valid = 1'b1;
      k = 0; cyc = 0; fin = 1'b0;
      @(negedge clk);
      while (!fin && cyc < 80) begin
         chk(req_ready == 1'b0, "R8 busy", 32'(req_ready), 0);
         if (cyc == 0 && ill) chk(done_valid == 1'b1, "R5 early done", 32'(done_valid), 1);
         xfer_ready = 1'b0;
         if (xfer_valid) begin
            chk(!ill && k < n, "R5/R10 transfer allowed", 32'(k), 32'(n));
            if (k < n) begin
               chk(xfer_idx == order[k], ed ? "R2 index" : "R1 index", 32'(xfer_idx), 32'(order[k]));
               chk(xfer_addr == (ed ? b - 32'(4 * k) : b + 32'(4 * k)),
                   ed ? "R2 addr (R7 when stalled)" : "R1 addr (R7 when stalled)", xfer_addr,
                   ed ? b - 32'(4 * k) : b + 32'(4 * k));
            end
            chk(xfer_load == ld, "R10 direction", 32'(xfer_load), 32'(ld));
            xfer_ready = (rnd() % 4) != 0;
            xfer_rdata = (xfer_idx == 4'd15) ? pcw : rnd();
            if (xfer_ready) k++;
         end
         if (done_valid) begin
            chk(done_illegal == ill, "R5 illegal flag", 32'(done_illegal), 32'(ill));
            chk(k == (ill ? 0 : n), "R10 transfer count", 32'(k), 32'(ill ? 0 : n));
            chk(done_wb_en == (ew & !ill), "R3 wb enable", 32'(done_wb_en), 32'(ew & !ill));
            if (!ill) begin
               chk(done_wb_value == ewv, "R3 wb value", done_wb_value, ewv);
               chk(done_wb_idx == ei, "R4/R3 wb index", 32'(done_wb_idx), 32'(ei));
               chk(done_fault == (ld & m[15] & !pcw[0]), "R6 fault", 32'(done_fault),
                   32'(ld & m[15] & !pcw[0]));
               chk(done_branch == (ld & m[15] & pcw[0]), "R6 branch", 32'(done_branch),
                   32'(ld & m[15] & pcw[0]));
               if (ld & m[15] & pcw[0])
                  chk(done_target == {pcw[31:1], 1'b0}, "R6 target", done_target, {pcw[31:1], 1'b0});
            end
            done_ready = 1'b1;
            req_valid  = 1'b0;
            fin = 1'b1;
         end
         @(negedge clk);
         cyc++;
      end
      chk(fin, "R8 completion reached", 32'(fin), 1);
      done_ready = 1'b0;
      xfer_ready = 1'b0;
      req_valid  = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      rst = 1'b1; req_valid = 1'b0; req_mask = '0; req_base_idx = '0; req_base = '0;
      req_dec = 1'b0; req_load = 1'b0; req_wb = 1'b0; req_stack = 1'b0;
      xfer_ready = 1'b0; xfer_rdata = '0; done_ready = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(xfer_valid == 1'b0, "R9 no transfer", 32'(xfer_valid), 0);
      chk(done_valid == 1'b0, "R9 no completion", 32'(done_valid), 0);
      chk(req_ready == 1'b1, "R9 idle", 32'(req_ready), 1);

      // single-register sweeps in both modes, loads and stores
      for (int r = 0; r < 16; r++) begin
         for (int d = 0; d < 2; d++) begin
            run_req(16'(1 << r), 4'd0, 32'h1000_0100, d[0], 1'b1, 1'b0, 1'b0, 32'h0000_4001 + 32'(r * 2));
            run_req(16'(1 << r), 4'd1, 32'h2000_0000, d[0], 1'b0, 1'b0, 1'b0, 32'h0);
         end
      end
      // PC loads: first in descending order, last in ascending order (R6)
      run_req(16'h80FF, 4'd12, 32'h0000_8000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_3001);
      run_req(16'h80FF, 4'd12, 32'h0000_8000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_3000);
      run_req(16'h8003, 4'd4, 32'h0000_8000, 1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
      // stack aliases (R4)
      run_req(16'h4FF0, 4'd2, 32'h2000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0);
      run_req(16'h80F0, 4'd2, 32'h2000_0FE0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0401);
      // each illegal case (R5)
      run_req(16'h0003, 4'd15, 32'h100, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
      run_req(16'h2001, 4'd0, 32'h100, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
      run_req(16'h0000, 4'd0, 32'h100, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
      run_req(16'h8001, 4'd1, 32'h100, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
      run_req(16'hC001, 4'd1, 32'h100, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1);
      run_req(16'h0024, 4'd5, 32'h100, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0);
      run_req(16'h0024, 4'd5, 32'h100, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
      // random sweep
      for (int t = 0; t < 500; t++) begin
         logic [31:0] a, bb, cc;
         logic [15:0] mm;
         a = rnd(); bb = rnd(); cc = rnd();
         mm = a[31:16];
         if (a[1:0] != 2'b00) mm[13] = 1'b0;
         run_req(mm, bb[3:0], {bb[31:4], 4'b0} ^ cc, a[2], a[3], a[4], (a[7:5] == 3'd0), cc);
      end
      summary();
   end
endmodule